// File: doc/BRIEF.md
# Bank-Aware DDR SDRAM Command Issuer

This block sits between a request source and the command pins of a four-bank DDR SDRAM. Each request carries a linear word address, a read/write flag and a hint asking that the row be closed once the burst ends. The block splits the address into column, bank and row fields. It keeps the open row of every bank, and from that record it picks the shortest legal command sequence for each request.

A request that hits the open row of its bank goes straight to a column command. A request to a closed bank first activates the row. A request to a bank that holds a different row first precharges that bank, then activates the new row, then sends the column command. Per-bank counters hold back each command until its bank's ACTIVE-to-column, PRECHARGE-to-ACTIVE and ACTIVE-to-PRECHARGE minimums have passed. A shared counter spaces column commands by half the burst length. When the hint is set, the block raises A10 on the column command and treats the bank as closed. It then waits for the device's self-timed precharge to finish before it activates that bank again.

Only one request is in flight at a time. The timers are per bank, so a new bank can be activated while another bank is still inside its minimum row-active window.

Top module: `ddr_cmd_issuer`

## Requirements
- R1: The request address maps column from bits [8:0], bank from bits [10:9] and row from bits [23:11]. The bank appears on `ba` and the row on `a` for ACTIVE. The column appears on `a[8:0]` for READ and WRITE, with `a[9]`, `a[11]` and `a[12]` low.
- R2: Command pins use {ras_n,cas_n,we_n} encodings ACTIVE=011, READ=101, WRITE=100, PRECHARGE=010, with `cs_n` low. In every cycle without a command, including after reset, `cs_n`, `ras_n`, `cas_n` and `we_n` are all high.
- R3: A request to a closed bank produces ACTIVE and then the column command. The column command comes exactly T_RCD cycles after the ACTIVE.
- R4: A request whose row equals the open row of its bank produces only the column command.
- R5: A request to a bank with a different open row produces PRECHARGE with `a[10]` low, then ACTIVE exactly T_RP cycles later. The PRECHARGE comes no sooner than T_RAS cycles after that bank's previous ACTIVE.
- R6: Two column commands are at least BURST_LEN/2 cycles apart, and a PRECHARGE is at least BURST_LEN/2 cycles after the last column command.
- R7: With the hint set, the column command carries `a[10]` high and the bank counts as closed. The next ACTIVE to that bank comes no sooner than BURST_LEN/2+T_RP cycles after the column command, and no sooner than T_RAS+T_RP cycles after the bank's prior ACTIVE.
- R8: `issued` is high for exactly the cycles in which a READ or WRITE is on the pins.
- R9: `req_ready` is high only when no request is in flight. It drops in the cycle after a request is accepted and stays low until that request's column command is issued.
- R10: Timing is tracked per bank, so an ACTIVE to one bank may issue while another open bank is still inside its T_RAS window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Linear address {row, bank, column} |
| req_autopre | input | 1 | Close the row after this burst |
| cs_n | output | 1 | Chip select, low during a command |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write enable |
| ba | output | 2 | Bank address |
| a | output | 13 | Row / column address bus |
| issued | output | 1 | One-cycle pulse with each READ or WRITE |

## Verification
The hardest cases to reach are an ACTIVE that follows an auto-precharged column command on the same bank, and an ACTIVE to a second bank that lands inside the first bank's T_RAS window. Both depend on how requests are spaced relative to counters hidden inside the block. The stimulus sends requests back to back as soon as `req_ready` rises, which places the second-bank activation within a few cycles of the first. It also places a re-access of a bank right after its self-closing write, so that the bank's recovery timer alone decides when the ACTIVE issues. A bench-side model of open rows predicts each command sequence, and the monitor measures the gaps between commands on each bank.

// File: rtl/ddrq_pkg.sv
package ddrq_pkg;
   // {ras_n, cas_n, we_n}
   typedef enum logic [2:0] {
      CMD_NOP = 3'b111,
      CMD_ACT = 3'b011,
      CMD_RD  = 3'b101,
      CMD_WR  = 3'b100,
      CMD_PRE = 3'b010
   } ddrq_cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PRE,
      ST_ACT,
      ST_COL
   } ddrq_state_e;
endpackage

// File: rtl/ddrq_gap.sv
module ddrq_gap #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             ok
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign ok = (cnt == '0);
endmodule

// File: rtl/ddrq_bank.sv
module ddrq_bank #(
   parameter int ROW_W   = 13,
   parameter int CNT_W   = 5,
   parameter int T_RCD   = 3,
   parameter int T_RP    = 3,
   parameter int T_RAS   = 7,
   parameter int COL_GAP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act,
   input  logic             pre,
   input  logic             col,
   input  logic             col_ap,
   input  logic [ROW_W-1:0] act_row,
   output logic             is_open,
   output logic [ROW_W-1:0] open_row,
   output logic             act_ok,
   output logic             col_ok,
   output logic             pre_ok
);
   logic [CNT_W-1:0] ras_cnt;
   logic [CNT_W-1:0] rp_val;
   logic [CNT_W-1:0] close_at;

   // Internal precharge starts at the later of burst end and tRAS expiry.
   assign close_at = (ras_cnt > CNT_W'(COL_GAP)) ? ras_cnt : CNT_W'(COL_GAP);
   assign rp_val   = (col && col_ap) ? close_at + CNT_W'(T_RP - 1) : CNT_W'(T_RP - 1);

   ddrq_gap #(.CNT_W(CNT_W)) u_rcd (
      .clk(clk), .rst_n(rst_n), .load(act),
      .load_val(CNT_W'(T_RCD - 1)), .ok(col_ok)
   );

   ddrq_gap #(.CNT_W(CNT_W)) u_rp (
      .clk(clk), .rst_n(rst_n), .load(pre || (col && col_ap)),
      .load_val(rp_val), .ok(act_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)              ras_cnt <= '0;
      else if (act)            ras_cnt <= CNT_W'(T_RAS - 1);
      else if (ras_cnt != '0)  ras_cnt <= ras_cnt - 1'b1;
   end
   assign pre_ok = (ras_cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open  <= 1'b0;
         open_row <= '0;
      end else if (act) begin
         is_open  <= 1'b1;
         open_row <= act_row;
      end else if (pre || (col && col_ap)) begin
         is_open  <= 1'b0;
      end
   end
endmodule

// File: rtl/ddr_cmd_issuer.sv
module ddr_cmd_issuer
   import ddrq_pkg::*;
#(
   parameter int ROW_W     = 13,
   parameter int COL_W     = 9,
   parameter int BANK_W    = 2,
   parameter int BURST_LEN = 4,
   parameter int T_RCD     = 3,
   parameter int T_RP      = 3,
   parameter int T_RAS     = 7
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   output logic                            req_ready,
   input  logic                            req_write,
   input  logic [ROW_W+BANK_W+COL_W-1:0]   req_addr,
   input  logic                            req_autopre,
   output logic                            cs_n,
   output logic                            ras_n,
   output logic                            cas_n,
   output logic                            we_n,
   output logic [BANK_W-1:0]               ba,
   output logic [ROW_W-1:0]                a,
   output logic                            issued
);
   localparam int NBANK   = 1 << BANK_W;
   localparam int COL_GAP = BURST_LEN / 2;
   localparam int CNT_W   = $clog2(T_RAS + T_RP + COL_GAP + 2);
   localparam int AP_BIT  = 10;

   if (BURST_LEN != 2 && BURST_LEN != 4 && BURST_LEN != 8) begin : g_bad_bl
      $error("BURST_LEN must be 2, 4 or 8");
   end
   if (ROW_W <= AP_BIT || COL_W > AP_BIT) begin : g_bad_width
      $error("address bus must hold bit 10 above the column field");
   end
   if (T_RCD < 1 || T_RP < 1 || T_RAS < 1) begin : g_bad_timing
      $error("timing minimums must be at least one cycle");
   end

   ddrq_state_e       state;
   logic              q_wr, q_ap;
   logic [BANK_W-1:0] q_bank;
   logic [ROW_W-1:0]  q_row;
   logic [COL_W-1:0]  q_col;

   logic [COL_W-1:0]  in_col;
   logic [BANK_W-1:0] in_bank;
   logic [ROW_W-1:0]  in_row;
   assign in_col  = req_addr[COL_W-1:0];
   assign in_bank = req_addr[COL_W +: BANK_W];
   assign in_row  = req_addr[COL_W+BANK_W +: ROW_W];

   logic [NBANK-1:0]  b_open, b_act_ok, b_col_ok, b_pre_ok;
   logic [ROW_W-1:0]  b_row [NBANK];
   logic              gap_ok;
   logic              accept, do_act, do_pre, do_col;
   logic [ROW_W-1:0]  col_addr;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign do_pre    = (state == ST_PRE) && b_pre_ok[q_bank] && gap_ok;
   assign do_act    = (state == ST_ACT) && b_act_ok[q_bank];
   assign do_col    = (state == ST_COL) && b_col_ok[q_bank] && gap_ok;

   always_comb begin
      col_addr              = '0;
      col_addr[COL_W-1:0]   = q_col;
      col_addr[AP_BIT]      = q_ap;
   end

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      ddrq_bank #(
         .ROW_W(ROW_W), .CNT_W(CNT_W), .T_RCD(T_RCD),
         .T_RP(T_RP), .T_RAS(T_RAS), .COL_GAP(COL_GAP)
      ) u_bank (
         .clk(clk), .rst_n(rst_n),
         .act(do_act && (q_bank == BANK_W'(g))),
         .pre(do_pre && (q_bank == BANK_W'(g))),
         .col(do_col && (q_bank == BANK_W'(g))),
         .col_ap(q_ap),
         .act_row(q_row),
         .is_open(b_open[g]),
         .open_row(b_row[g]),
         .act_ok(b_act_ok[g]),
         .col_ok(b_col_ok[g]),
         .pre_ok(b_pre_ok[g])
      );
   end

   ddrq_gap #(.CNT_W(CNT_W)) u_colgap (
      .clk(clk), .rst_n(rst_n), .load(do_col),
      .load_val(CNT_W'(COL_GAP - 1)), .ok(gap_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         q_wr   <= 1'b0;
         q_ap   <= 1'b0;
         q_bank <= '0;
         q_row  <= '0;
         q_col  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (accept) begin
               q_wr   <= req_write;
               q_ap   <= req_autopre;
               q_bank <= in_bank;
               q_row  <= in_row;
               q_col  <= in_col;
               if (b_open[in_bank] && b_row[in_bank] == in_row) state <= ST_COL;
               else if (b_open[in_bank])                       state <= ST_PRE;
               else                                            state <= ST_ACT;
            end
            ST_PRE: if (do_pre) state <= ST_ACT;
            ST_ACT: if (do_act) state <= ST_COL;
            ST_COL: if (do_col) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   ddrq_cmd_e cmd_q;
   assign {ras_n, cas_n, we_n} = cmd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_n   <= 1'b1;
         cmd_q  <= CMD_NOP;
         ba     <= '0;
         a      <= '0;
         issued <= 1'b0;
      end else begin
         cs_n   <= 1'b1;
         cmd_q  <= CMD_NOP;
         ba     <= '0;
         a      <= '0;
         issued <= 1'b0;
         if (do_pre) begin
            cs_n  <= 1'b0;
            cmd_q <= CMD_PRE;
            ba    <= q_bank;
         end else if (do_act) begin
            cs_n  <= 1'b0;
            cmd_q <= CMD_ACT;
            ba    <= q_bank;
            a     <= q_row;
         end else if (do_col) begin
            cs_n   <= 1'b0;
            cmd_q  <= q_wr ? CMD_WR : CMD_RD;
            ba     <= q_bank;
            a      <= col_addr;
            issued <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/ddrq_chk.sv
module ddrq_chk #(
   parameter int ROW_W     = 13,
   parameter int BURST_LEN = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             cs_n,
   input logic             ras_n,
   input logic             cas_n,
   input logic             we_n,
   input logic [ROW_W-1:0] a,
   input logic             issued
);
   logic colcmd, precmd;
   assign colcmd = !cs_n && ras_n && !cas_n;
   assign precmd = !cs_n && !ras_n && cas_n && !we_n;

   // R8
   issued_has_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issued |-> colcmd);
   // R8
   col_has_issued_chk: assert property (@(posedge clk) disable iff (!rst_n)
      colcmd |-> issued);
   // R9
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   // R2
   quiet_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (cs_n && ras_n && cas_n && we_n));
   // R5
   pre_single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      precmd |-> !a[10]);
   // R6
   col_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (BURST_LEN > 2 && colcmd) |=> !colcmd);
endmodule

bind ddr_cmd_issuer ddrq_chk #(.ROW_W(ROW_W), .BURST_LEN(BURST_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a(a), .issued(issued)
);

// File: tb/sim_ddr_cmd_issuer.sv
module sim_ddr_cmd_issuer;
   localparam int CLK_PERIOD = 10;
   localparam int T_RCD = 3;
   localparam int T_RP  = 3;
   localparam int T_RAS = 7;
   localparam int BL    = 4;
   localparam int GAP   = BL / 2;

   localparam int K_ACT = 0, K_PRE = 1, K_RD = 2, K_WR = 3;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_write = 0, req_autopre = 0;
   logic [23:0] req_addr = '0;
   logic req_ready, cs_n, ras_n, cas_n, we_n, issued;
   logic [1:0] ba;
   logic [12:0] a;

   always #(CLK_PERIOD/2) clk = ~clk;

   ddr_cmd_issuer #(.BURST_LEN(BL), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_autopre(req_autopre),
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba(ba), .a(a), .issued(issued)
   );

   typedef struct { int kind; logic [1:0] bank; logic [12:0] addr; } exp_t;
   exp_t expq[$];

   int checks = 0, errors = 0;
   bit done = 0;
   bit m_open [4];
   logic [12:0] m_row [4];

   task automatic chk(input bit ok, input string what, input int actual, input int expected);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", what, actual, expected);
      end
   endtask

   task automatic push(input int k, input logic [1:0] b, input logic [12:0] ad);
      exp_t e;
      e.kind = k; e.bank = b; e.addr = ad;
      expq.push_back(e);
   endtask

   // R1 mapping: {row[23:11], bank[10:9], col[8:0]}
   task automatic send(input bit wr, input logic [1:0] b, input logic [12:0] row,
                       input logic [8:0] col, input bit ap);
      if (m_open[b] && m_row[b] == row) begin
      end else if (m_open[b]) begin
         push(K_PRE, b, 13'd0);
         push(K_ACT, b, row);
      end else begin
         push(K_ACT, b, row);
      end
      push(wr ? K_WR : K_RD, b, {2'b00, ap, 1'b0, col});
      m_open[b] = !ap;
      m_row[b]  = row;
      @(negedge clk);
      req_valid = 1; req_write = wr; req_autopre = ap; req_addr = {row, b, col};
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 0;
      chk(!req_ready, "R9 ready low after accept", int'(req_ready), 0);
   endtask

   // monitor state
   int cyc = 0;
   int last_act [4], last_pre [4], last_colb [4], lastk [4];
   bit apc [4], obs_open [4];
   int last_col = -1000;
   bit overlap_seen = 0;

   initial begin
      for (int i = 0; i < 4; i++) begin
         last_act[i] = -1000; last_pre[i] = -1000; last_colb[i] = -1000;
         lastk[i] = -1; apc[i] = 0; obs_open[i] = 0; m_open[i] = 0; m_row[i] = '0;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit colc;
         int k, b;
         cyc++;
         colc = !cs_n && ras_n && !cas_n;
         if (colc || issued)
            chk(colc == issued, "R8 issued matches column command", int'(issued), int'(colc));
         if (!cs_n) begin
            b = int'(ba);
            case ({ras_n, cas_n, we_n})
               3'b011:  k = K_ACT;
               3'b010:  k = K_PRE;
               3'b101:  k = K_RD;
               3'b100:  k = K_WR;
               default: k = -1;
            endcase
            if (expq.size() == 0) begin
               chk(0, "R2 unexpected command", k, -1);
            end else begin
               exp_t e;
               e = expq.pop_front();
               chk(k == e.kind, "R2 command kind", k, e.kind);
               chk(ba == e.bank, "R1 bank field", int'(ba), int'(e.bank));
               chk(a == e.addr, "R1 address bus", int'(a), int'(e.addr));
            end
            if (k == K_ACT) begin
               if (lastk[b] == K_PRE)
                  chk(cyc - last_pre[b] == T_RP, "R5 PRE to ACT gap", cyc - last_pre[b], T_RP);
               if (apc[b]) begin
                  chk(cyc - last_colb[b] >= GAP + T_RP, "R7 AP column to ACT gap",
                      cyc - last_colb[b], GAP + T_RP);
                  chk(cyc - last_act[b] >= T_RAS + T_RP, "R7 ACT to ACT via AP",
                      cyc - last_act[b], T_RAS + T_RP);
               end
               for (int o = 0; o < 4; o++)
                  if (o != b && obs_open[o] && (cyc - last_act[o] < T_RAS)) overlap_seen = 1;
               last_act[b] = cyc; lastk[b] = K_ACT; apc[b] = 0; obs_open[b] = 1;
            end else if (k == K_PRE) begin
               chk(cyc - last_act[b] >= T_RAS, "R5 ACT to PRE gap", cyc - last_act[b], T_RAS);
               chk(cyc - last_col >= GAP, "R6 column to PRE gap", cyc - last_col, GAP);
               last_pre[b] = cyc; lastk[b] = K_PRE; obs_open[b] = 0;
            end else if (k == K_RD || k == K_WR) begin
               if (lastk[b] == K_ACT)
                  chk(cyc - last_act[b] == T_RCD, "R3 ACT to column gap", cyc - last_act[b], T_RCD);
               chk(cyc - last_col >= GAP, "R6 column spacing", cyc - last_col, GAP);
               if (a[10]) begin apc[b] = 1; obs_open[b] = 0; end
               last_col = cyc; last_colb[b] = cyc; lastk[b] = k;
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired actual 1 expected 0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R2: quiet pins after reset
      chk(cs_n && ras_n && cas_n && we_n, "R2 pins idle after reset",
          int'({cs_n, ras_n, cas_n, we_n}), 15);
      chk(!issued, "R8 no pulse after reset", int'(issued), 0);
      chk(req_ready, "R9 ready after reset", int'(req_ready), 1);

      send(0, 2'd0, 13'd5, 9'd3, 0);        // R3 closed bank
      send(0, 2'd0, 13'd5, 9'd8, 0);        // R4 row hit
      send(0, 2'd1, 13'd2, 9'd1, 0);        // R10 second bank inside tRAS of first
      send(1, 2'd0, 13'd9, 9'd4, 0);        // R5 row miss
      send(1, 2'd2, 13'd100, 9'd511, 1);    // R7 auto precharge
      send(0, 2'd2, 13'd100, 9'd0, 0);      // R7 reopen after self-close
      send(0, 2'd3, 13'd8191, 9'd0, 0);     // R1 top row
      send(1, 2'd3, 13'd8191, 9'd511, 1);   // R4 hit then R7 close
      send(1, 2'd1, 13'd4000, 9'd77, 0);    // R5 miss on bank 1

      while (expq.size() != 0) @(negedge clk);
      repeat (12) @(negedge clk);
      chk(expq.size() == 0, "R2 all expected commands seen", expq.size(), 0);
      chk(overlap_seen, "R10 ACT overlapped another bank's tRAS", int'(overlap_seen), 1);
      chk(req_ready, "R9 ready when drained", int'(req_ready), 1);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule